// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a small bank of control registers on a simple memory-mapped bus. Each register sits in its own address window, and a one-hot select input picks the window. A small offset field addresses bytes within the window. Every register responds only at offset zero. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from the stored values, and the result is zero-extended onto a 32-bit read bus.

Three registers are plain storage: a configuration byte, a diagnostic byte and a modem-control byte. A 16-bit latch drives a row of indicator LEDs. The remaining registers have side effects when written:
- The first auxiliary byte fires a one-cycle terminal-count strobe toward a floppy controller.
- The second auxiliary byte handles software power-down. It carries a power-off request bit, a write-to-clear bit for the power-fail flag, and the power-fail flag itself.
- The 32-bit system control register raises a one-cycle system reset request. It also leaves a sticky reset-status value behind.

The power-fail flag follows the power-fail input each time that input changes, gated by an enable bit in the configuration byte. The interrupt output is the flag qualified by the same enable bit. Block reset clears only part of the state. The diagnostic byte, the LED latch and the system control register keep their contents, so software can read the reset status after the reset it requested.

Top module: `aux_sysctl`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears the configuration, modem-control, first auxiliary and second auxiliary registers and drives all pulse outputs and `pwr_irq` low. It leaves the diagnostic register, the LED latch and the system control register unchanged.
- R2: Window selects are one-hot: bit 0 configuration, 1 diagnostic, 2 modem control, 3 LED latch, 4 system control, 5 first auxiliary, 6 second auxiliary. A register is read and written only when `ofs` is 0. At any other offset, writes are ignored and reads return 0. Byte registers return data in bits 7:0, the LED latch in bits 15:0, and all upper bits read 0.
- R3: A write to the first auxiliary register with bit 1 set produces `tc_pulse` high for exactly the one cycle after the write edge. The value stored is the written byte with bit 1 forced to 0.
- R4: A write to the second auxiliary register keeps only bits 0 (power-off) and 1 (flag clear) of the data, and preserves the stored power-fail flag in bit 5. If bit 1 of the data is set, only bit 0 is stored, which clears the flag. Bit 1 never reads back as 1.
- R5: A write to the second auxiliary register with bit 0 set drives `pwroff_req` high for exactly one cycle after the write edge.
- R6: At the first clock edge after `pwr_fail_in` changes level, the flag (bit 5 of the second auxiliary register) becomes `pwr_fail_in` AND configuration bit 3. While the input is steady, the flag changes only through R4 writes or reset.
- R7: `pwr_irq` equals the power-fail flag AND configuration bit 3. Clearing configuration bit 3 drops the interrupt without clearing the flag.
- R8: A system control write with bit 0 set loads the register with 0x00000002 and drives `sys_rst_req` high for one cycle. A write with bit 0 clear changes nothing and raises no request.
- R9: The configuration, diagnostic and modem-control bytes and the 16-bit LED latch store the written value and read it back. `led_out` always shows the latch.
- R10: If a power-fail input change and a flag-clearing write to the second auxiliary register land on the same edge, the input change decides the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 7 | One-hot register window select |
| ofs | input | 2 | Byte offset within the selected window |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| pwr_fail_in | input | 1 | Power-fail indication from the supply monitor |
| pwr_irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | One-cycle terminal-count strobe to the floppy controller |
| pwroff_req | output | 1 | One-cycle power-off request |
| sys_rst_req | output | 1 | One-cycle system reset request |
| led_out | output | 16 | LED latch contents |

## Verification
Reads are combinational, so a wrong stored value shows on `rdata` in the same cycle the window is selected after the faulty write edge. A misplaced mask bit or a wrong reset membership is visible on the very next read. A broken power-fail path shows up in two places one cycle after the input edge: bit 5 of the second auxiliary register and `pwr_irq`. A pulse that is stretched, missing or raised by the wrong write shows on its output exactly one cycle after the write edge, and the bench samples there and again one cycle later.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;

   // Window select positions (one-hot bit index of sel)
   localparam int W_CFG    = 0;
   localparam int W_DIAG   = 1;
   localparam int W_MODEM  = 2;
   localparam int W_LED    = 3;
   localparam int W_SYSCTL = 4;
   localparam int W_AUX1   = 5;
   localparam int W_AUX2   = 6;
   localparam int NUM_WIN  = 7;

   localparam int BYTE_W   = 8;

   typedef logic [BYTE_W-1:0] byte_t;

endpackage

// File: rtl/aux_sysctl_decode.sv
module aux_sysctl_decode #(
   parameter int NUM_WIN = 7,
   parameter int OFS_W   = 2
) (
   input  logic [NUM_WIN-1:0] sel,
   input  logic [OFS_W-1:0]   ofs,
   input  logic               wr_en,
   output logic [NUM_WIN-1:0] wr_stb,
   output logic [NUM_WIN-1:0] rd_hit
);

   logic ofs_zero;
   assign ofs_zero = (ofs == '0);

   // One strobe per window; only offset zero is decoded
   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      assign rd_hit[i] = sel[i] & ofs_zero;
      assign wr_stb[i] = sel[i] & ofs_zero & wr_en;
   end

endmodule

// File: rtl/aux_sysctl_store.sv
module aux_sysctl_store
   import aux_sysctl_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          LED_W       = 16,
   parameter int          TC_BIT      = 1,
   parameter int          SYSRST_BIT  = 0,
   parameter logic [31:0] SYSSTAT_VAL = 32'h2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb_cfg,
   input  logic              stb_diag,
   input  logic              stb_modem,
   input  logic              stb_led,
   input  logic              stb_sys,
   input  logic              stb_aux1,
   input  logic [DATA_W-1:0] wdata,
   output byte_t             cfg_q,
   output byte_t             diag_q,
   output byte_t             modem_q,
   output byte_t             aux1_q,
   output logic [LED_W-1:0]  led_q,
   output logic [DATA_W-1:0] sys_q,
   output logic              tc_q,
   output logic              rstreq_q
);

   localparam byte_t             TC_MASK  = byte_t'(1) << TC_BIT;
   localparam logic [DATA_W-1:0] SYS_MASK = DATA_W'(1) << SYSRST_BIT;

   byte_t wbyte;
   logic  tc_hit;
   logic  sys_hit;

   assign wbyte   = wdata[BYTE_W-1:0];
   assign tc_hit  = stb_aux1 && ((wbyte & TC_MASK) != '0);
   assign sys_hit = stb_sys && ((wdata & SYS_MASK) != '0);

   // Registers cleared by block reset, plus the pulse flops
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         modem_q  <= '0;
         aux1_q   <= '0;
         tc_q     <= 1'b0;
         rstreq_q <= 1'b0;
      end else begin
         if (stb_cfg)   cfg_q   <= wbyte;
         if (stb_modem) modem_q <= wbyte;
         if (stb_aux1)  aux1_q  <= wbyte & ~TC_MASK;
         tc_q     <= tc_hit;
         rstreq_q <= sys_hit;
      end
   end

   // Registers that survive block reset
   always_ff @(posedge clk) begin
      if (stb_diag) diag_q <= wbyte;
      if (stb_led)  led_q  <= wdata[LED_W-1:0];
      if (sys_hit)  sys_q  <= DATA_W'(SYSSTAT_VAL);
   end

endmodule

// File: rtl/aux_sysctl_pwr.sv
module aux_sysctl_pwr
   import aux_sysctl_pkg::*;
#(
   parameter int PWROFF_BIT = 0,
   parameter int PFCLR_BIT  = 1,
   parameter int PFFLAG_BIT = 5,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  stb_aux2,
   input  byte_t wbyte,
   input  logic  irq_en,
   input  logic  pf_in,
   output byte_t aux2_q,
   output logic  irq,
   output logic  pwroff_q
);

   localparam byte_t OFF_MASK  = byte_t'(1) << PWROFF_BIT;
   localparam byte_t CLR_MASK  = byte_t'(1) << PFCLR_BIT;
   localparam byte_t FLAG_MASK = byte_t'(1) << PFFLAG_BIT;

   logic  pf_q;
   logic  pf_edge;
   byte_t wr_val;
   byte_t aux2_d;
   logic  off_hit;

   assign pf_edge = pf_in ^ pf_q;
   assign off_hit = stb_aux2 && ((wbyte & OFF_MASK) != '0);

   // Value a software write would store
   always_comb begin
      wr_val = (wbyte & (OFF_MASK | CLR_MASK)) | (aux2_q & FLAG_MASK);
      if ((wbyte & CLR_MASK) != '0) wr_val = wr_val & OFF_MASK;
   end

   // Input change is applied last so it decides the flag
   always_comb begin
      aux2_d = stb_aux2 ? wr_val : aux2_q;
      if (pf_edge) aux2_d[PFFLAG_BIT] = pf_in & irq_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aux2_q   <= '0;
         pf_q     <= 1'b0;
         pwroff_q <= 1'b0;
      end else begin
         aux2_q   <= aux2_d;
         pf_q     <= pf_in;
         pwroff_q <= off_hit;
      end
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= aux2_q[PFFLAG_BIT] & irq_en;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = aux2_q[PFFLAG_BIT] & irq_en;
   end

endmodule

// File: rtl/aux_sysctl.sv
module aux_sysctl
   import aux_sysctl_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          OFS_W       = 2,
   parameter int          LED_W       = 16,
   parameter int          TC_BIT      = 1,
   parameter int          PWROFF_BIT  = 0,
   parameter int          PFCLR_BIT   = 1,
   parameter int          PFFLAG_BIT  = 5,
   parameter int          IRQEN_BIT   = 3,
   parameter int          SYSRST_BIT  = 0,
   parameter logic [31:0] SYSSTAT_VAL = 32'h2,
   parameter bit          IRQ_REG     = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_WIN-1:0] sel,
   input  logic [OFS_W-1:0]   ofs,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   input  logic               pwr_fail_in,
   output logic               pwr_irq,
   output logic               tc_pulse,
   output logic               pwroff_req,
   output logic               sys_rst_req,
   output logic [LED_W-1:0]   led_out
);

   // Elaboration-time parameter checks
   if (DATA_W < 32)        begin : g_chk_dw  $error("DATA_W must be at least 32"); end
   if (LED_W > DATA_W)     begin : g_chk_led $error("LED_W exceeds DATA_W"); end
   if (OFS_W < 1)          begin : g_chk_ofs $error("OFS_W must be at least 1"); end
   if (TC_BIT >= BYTE_W || PWROFF_BIT >= BYTE_W || PFCLR_BIT >= BYTE_W ||
       PFFLAG_BIT >= BYTE_W || IRQEN_BIT >= BYTE_W)
                           begin : g_chk_bit $error("control bit outside byte"); end
   if (PWROFF_BIT == PFCLR_BIT || PFFLAG_BIT == PWROFF_BIT || PFFLAG_BIT == PFCLR_BIT)
                           begin : g_chk_ovl $error("second aux bits overlap"); end
   if (SYSRST_BIT >= DATA_W) begin : g_chk_sr $error("SYSRST_BIT outside word"); end

   logic [NUM_WIN-1:0] wr_stb;
   logic [NUM_WIN-1:0] rd_hit;

   byte_t             cfg_q;
   byte_t             diag_q;
   byte_t             modem_q;
   byte_t             aux1_q;
   byte_t             aux2_q;
   logic [LED_W-1:0]  led_q;
   logic [DATA_W-1:0] sys_q;

   aux_sysctl_decode #(
      .NUM_WIN (NUM_WIN),
      .OFS_W   (OFS_W)
   ) decode_i (
      .sel    (sel),
      .ofs    (ofs),
      .wr_en  (wr_en),
      .wr_stb (wr_stb),
      .rd_hit (rd_hit)
   );

   aux_sysctl_store #(
      .DATA_W      (DATA_W),
      .LED_W       (LED_W),
      .TC_BIT      (TC_BIT),
      .SYSRST_BIT  (SYSRST_BIT),
      .SYSSTAT_VAL (SYSSTAT_VAL)
   ) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb_cfg   (wr_stb[W_CFG]),
      .stb_diag  (wr_stb[W_DIAG]),
      .stb_modem (wr_stb[W_MODEM]),
      .stb_led   (wr_stb[W_LED]),
      .stb_sys   (wr_stb[W_SYSCTL]),
      .stb_aux1  (wr_stb[W_AUX1]),
      .wdata     (wdata),
      .cfg_q     (cfg_q),
      .diag_q    (diag_q),
      .modem_q   (modem_q),
      .aux1_q    (aux1_q),
      .led_q     (led_q),
      .sys_q     (sys_q),
      .tc_q      (tc_pulse),
      .rstreq_q  (sys_rst_req)
   );

   aux_sysctl_pwr #(
      .PWROFF_BIT (PWROFF_BIT),
      .PFCLR_BIT  (PFCLR_BIT),
      .PFFLAG_BIT (PFFLAG_BIT),
      .IRQ_REG    (IRQ_REG)
   ) pwr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb_aux2 (wr_stb[W_AUX2]),
      .wbyte    (wdata[BYTE_W-1:0]),
      .irq_en   (cfg_q[IRQEN_BIT]),
      .pf_in    (pwr_fail_in),
      .aux2_q   (aux2_q),
      .irq      (pwr_irq),
      .pwroff_q (pwroff_req)
   );

   assign led_out = led_q;

   // Read path: zero-extend each window, mask by hit, OR together
   logic [DATA_W-1:0] win_data [NUM_WIN];
   logic [DATA_W-1:0] win_gated [NUM_WIN];

   always_comb begin
      win_data[W_CFG]    = DATA_W'(cfg_q);
      win_data[W_DIAG]   = DATA_W'(diag_q);
      win_data[W_MODEM]  = DATA_W'(modem_q);
      win_data[W_LED]    = DATA_W'(led_q);
      win_data[W_SYSCTL] = sys_q;
      win_data[W_AUX1]   = DATA_W'(aux1_q);
      win_data[W_AUX2]   = DATA_W'(aux2_q);
   end

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_rd
      assign win_gated[i] = rd_hit[i] ? win_data[i] : '0;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_WIN; i++) rdata = rdata | win_gated[i];
   end

endmodule

// File: rtl/aux_sysctl_chk.sv
module aux_sysctl_chk
   import aux_sysctl_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          OFS_W       = 2,
   parameter int          TC_BIT      = 1,
   parameter int          PWROFF_BIT  = 0,
   parameter int          IRQEN_BIT   = 3,
   parameter int          SYSRST_BIT  = 0,
   parameter logic [31:0] SYSSTAT_VAL = 32'h2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_WIN-1:0] sel,
   input logic [OFS_W-1:0]   ofs,
   input logic               wr_en,
   input logic [DATA_W-1:0]  wdata,
   input logic               pwr_irq,
   input logic               tc_pulse,
   input logic               pwroff_req,
   input logic               sys_rst_req,
   input logic [BYTE_W-1:0]  cfg_q,
   input logic [DATA_W-1:0]  sys_q
);

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel)); // R2

   AST_TC_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      tc_pulse |-> $past(wr_en && sel[W_AUX1] && ofs == '0 && wdata[TC_BIT])); // R3

   AST_PWROFF_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      pwroff_req |-> $past(wr_en && sel[W_AUX2] && ofs == '0 && wdata[PWROFF_BIT])); // R5

   AST_RSTREQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> $past(wr_en && sel[W_SYSCTL] && ofs == '0 && wdata[SYSRST_BIT])); // R8

   AST_RSTREQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> (sys_q == DATA_W'(SYSSTAT_VAL))); // R8

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q[IRQEN_BIT] && $past(!cfg_q[IRQEN_BIT])) |-> !pwr_irq); // R7

endmodule

bind aux_sysctl aux_sysctl_chk #(
   .DATA_W      (DATA_W),
   .OFS_W       (OFS_W),
   .TC_BIT      (TC_BIT),
   .PWROFF_BIT  (PWROFF_BIT),
   .IRQEN_BIT   (IRQEN_BIT),
   .SYSRST_BIT  (SYSRST_BIT),
   .SYSSTAT_VAL (SYSSTAT_VAL)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .sel         (sel),
   .ofs         (ofs),
   .wr_en       (wr_en),
   .wdata       (wdata),
   .pwr_irq     (pwr_irq),
   .tc_pulse    (tc_pulse),
   .pwroff_req  (pwroff_req),
   .sys_rst_req (sys_rst_req),
   .cfg_q       (cfg_q),
   .sys_q       (sys_q)
);

// File: tb/aux_sysctl_tb.sv
`timescale 1ns/1ps
module aux_sysctl_tb_top;
   import aux_sysctl_pkg::*;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NUM_WIN-1:0] sel = '0;
   logic [1:0]         ofs = '0;
   logic               wr_en = 1'b0;
   logic [31:0]        wdata = '0;
   logic [31:0]        rdata;
   logic               pwr_fail_in = 1'b0;
   logic               pwr_irq;
   logic               tc_pulse;
   logic               pwroff_req;
   logic               sys_rst_req;
   logic [15:0]        led_out;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   aux_sysctl dut_i (
      .clk(clk), .rst_n(rst_n), .sel(sel), .ofs(ofs), .wr_en(wr_en),
      .wdata(wdata), .rdata(rdata), .pwr_fail_in(pwr_fail_in),
      .pwr_irq(pwr_irq), .tc_pulse(tc_pulse), .pwroff_req(pwroff_req),
      .sys_rst_req(sys_rst_req), .led_out(led_out)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Write at offset; returns at the negedge after the write edge
   task automatic wr(input int win, input logic [1:0] o, input logic [31:0] d);
      @(negedge clk);
      sel = NUM_WIN'(1) << win; ofs = o; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; sel = '0; ofs = '0;
   endtask

   task automatic rd(input int win, input logic [1:0] o, output logic [31:0] d);
      sel = NUM_WIN'(1) << win; ofs = o;
      #0.5 d = rdata;
      sel = '0; ofs = '0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      logic [31:0] v;
      rd(W_CFG, 0, v);   check("R1", "cfg after reset", v, 0);
      rd(W_MODEM, 0, v); check("R1", "modem after reset", v, 0);
      rd(W_AUX1, 0, v);  check("R1", "aux1 after reset", v, 0);
      rd(W_AUX2, 0, v);  check("R1", "aux2 after reset", v, 0);
      check("R1", "outputs after reset", {pwr_irq, tc_pulse, pwroff_req, sys_rst_req}, 0);
   endtask

   task automatic t_storage();
      logic [31:0] v;
      wr(W_CFG, 0, 32'h0000_00A5);   rd(W_CFG, 0, v);   check("R9", "cfg", v, 32'hA5);
      wr(W_DIAG, 0, 32'hFFFF_FF3C);  rd(W_DIAG, 0, v);  check("R2", "diag zero-extended", v, 32'h3C);
      wr(W_MODEM, 0, 32'h5A);        rd(W_MODEM, 0, v); check("R9", "modem", v, 32'h5A);
      wr(W_LED, 0, 32'h1234_BEEF);   rd(W_LED, 0, v);   check("R9", "led read", v, 32'hBEEF);
      check("R9", "led_out", 32'(led_out), 32'hBEEF);
      wr(W_CFG, 0, 32'h00);
   endtask

   task automatic t_offsets();
      logic [31:0] v;
      wr(W_DIAG, 1, 32'h11);   rd(W_DIAG, 0, v); check("R2", "diag after ofs1 write", v, 32'h3C);
      rd(W_DIAG, 2, v);        check("R2", "diag read ofs2", v, 0);
      wr(W_LED, 3, 32'h0);     rd(W_LED, 0, v);  check("R2", "led after ofs3 write", v, 32'hBEEF);
      wr(W_SYSCTL, 1, 32'h1);  check("R2", "no rst req at ofs1", 32'(sys_rst_req), 0);
   endtask

   task automatic t_aux1_tc();
      logic [31:0] v;
      wr(W_AUX1, 0, 32'hFF);
      check("R3", "tc high after write", 32'(tc_pulse), 1);
      rd(W_AUX1, 0, v); check("R3", "aux1 bit1 cleared", v, 32'hFD);
      @(negedge clk); check("R3", "tc one cycle", 32'(tc_pulse), 0);
      wr(W_AUX1, 0, 32'h01);
      check("R3", "no tc without bit1", 32'(tc_pulse), 0);
      rd(W_AUX1, 0, v); check("R3", "aux1 plain", v, 32'h01);
   endtask

   task automatic t_aux2_write();
      logic [31:0] v;
      wr(W_AUX2, 0, 32'hFD);
      check("R5", "pwroff high", 32'(pwroff_req), 1);
      rd(W_AUX2, 0, v); check("R4", "aux2 masked", v, 32'h01);
      @(negedge clk); check("R5", "pwroff one cycle", 32'(pwroff_req), 0);
      wr(W_AUX2, 0, 32'h00);
      check("R5", "no pwroff", 32'(pwroff_req), 0);
      rd(W_AUX2, 0, v); check("R4", "aux2 cleared", v, 0);
   endtask

   task automatic t_power_fail();
      logic [31:0] v;
      wr(W_CFG, 0, 32'h08);
      pwr_fail_in = 1'b1; @(negedge clk);
      rd(W_AUX2, 0, v); check("R6", "flag set on rise", v, 32'h20);
      check("R7", "irq high", 32'(pwr_irq), 1);
      wr(W_AUX2, 0, 32'h00);
      rd(W_AUX2, 0, v); check("R4", "flag preserved", v, 32'h20);
      wr(W_CFG, 0, 32'h00);
      check("R7", "irq gated off", 32'(pwr_irq), 0);
      rd(W_AUX2, 0, v); check("R7", "flag kept when gated", v, 32'h20);
      wr(W_CFG, 0, 32'h08);
      check("R7", "irq back", 32'(pwr_irq), 1);
      wr(W_AUX2, 0, 32'h03);
      rd(W_AUX2, 0, v); check("R4", "clear bit drops flag", v, 32'h01);
      check("R7", "irq after clear", 32'(pwr_irq), 0);
      pwr_fail_in = 1'b0; @(negedge clk);
      wr(W_CFG, 0, 32'h00);
      pwr_fail_in = 1'b1; @(negedge clk);
      rd(W_AUX2, 0, v); check("R6", "no flag when disabled", v, 32'h01);
      wr(W_CFG, 0, 32'h08); @(negedge clk);
      rd(W_AUX2, 0, v); check("R6", "steady input no set", v, 32'h01);
      check("R7", "irq stays low", 32'(pwr_irq), 0);
      pwr_fail_in = 1'b0; @(negedge clk);
      pwr_fail_in = 1'b1; @(negedge clk);
      rd(W_AUX2, 0, v); check("R6", "flag on new rise", v, 32'h21);
      pwr_fail_in = 1'b0; @(negedge clk);
      rd(W_AUX2, 0, v); check("R6", "flag cleared on fall", v, 32'h01);
   endtask

   task automatic t_race();
      logic [31:0] v;
      @(negedge clk);
      pwr_fail_in = 1'b1;
      sel = NUM_WIN'(1) << W_AUX2; ofs = 0; wdata = 32'h02; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; sel = '0;
      rd(W_AUX2, 0, v); check("R10", "input change beats clear", v, 32'h20);
      check("R10", "irq on race", 32'(pwr_irq), 1);
      wr(W_AUX2, 0, 32'h02);
      pwr_fail_in = 1'b0; @(negedge clk);
   endtask

   task automatic t_sysctl();
      logic [31:0] v;
      wr(W_SYSCTL, 0, 32'h0000_0001);
      check("R8", "rst req high", 32'(sys_rst_req), 1);
      rd(W_SYSCTL, 0, v); check("R8", "status value", v, 32'h2);
      @(negedge clk); check("R8", "rst req one cycle", 32'(sys_rst_req), 0);
      wr(W_SYSCTL, 0, 32'hFFFF_FFFE);
      check("R8", "no req bit0 clear", 32'(sys_rst_req), 0);
      rd(W_SYSCTL, 0, v); check("R8", "status unchanged", v, 32'h2);
      rd(W_SYSCTL, 2, v); check("R2", "sysctl other ofs", v, 0);
   endtask

   task automatic t_reset_keep();
      logic [31:0] v;
      wr(W_CFG, 0, 32'h0C); wr(W_MODEM, 0, 32'h77); wr(W_AUX1, 0, 32'h81);
      do_reset();
      rd(W_SYSCTL, 0, v); check("R1", "sysctl survives", v, 32'h2);
      rd(W_DIAG, 0, v);   check("R1", "diag survives", v, 32'h3C);
      rd(W_LED, 0, v);    check("R1", "led survives", v, 32'hBEEF);
      rd(W_CFG, 0, v);    check("R1", "cfg cleared", v, 0);
      rd(W_MODEM, 0, v);  check("R1", "modem cleared", v, 0);
      rd(W_AUX1, 0, v);   check("R1", "aux1 cleared", v, 0);
   endtask

   initial begin
      #100000;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_storage();
      t_offsets();
      t_aux1_tc();
      t_aux2_write();
      t_power_fail();
      t_race();
      t_sysctl();
      t_reset_keep();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule